// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block collects interrupt requests from four sources and reports the most urgent one to a processor. A one-cycle request pulse from a source sets a sticky pending bit. A per-source allow bit decides whether that pending bit may raise an interrupt. A global enable flag gates the interrupt line as a whole.

A fixed-priority encoder picks the lowest-numbered source that is both pending and allowed. Its 2-bit code is merged into the low bits of a vector address. The vector is driven out, with its output enable, only while the processor holds the acknowledge input high. Acknowledge also drops the global enable, so nested interrupts are blocked until software turns it back on.

Software reaches the controller through a command port. Each command carries a bitmap that selects the sources it acts on.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, all pending bits, allow bits and the global enable are 0, so `int_o` is 0, `vec_oe_o` is 0 and `vec_o` is 0.
- R2: A 1 on `req_i[k]` at a clock edge sets pending bit k. The bit stays set after the request returns to 0, until software clears it.
- R3: Command 3 (clear pending) clears every pending bit whose `cmd_bits_i` bit is 1. If a request for the same bit arrives in the same cycle, the set wins.
- R4: Command 1 sets and command 2 clears the allow bits selected by `cmd_bits_i`. An allow bit of 1 lets its source interrupt. A pending bit whose allow bit is 0 stays pending and raises no interrupt.
- R5: Command 4 sets and command 5 clears the global enable. `int_o` is 1 exactly when the global enable is 1 and at least one source is both pending and allowed.
- R6: Source 0 has the highest priority and source 3 the lowest. The code is the index of the lowest-numbered source that is pending and allowed, with bit 1 as x and bit 0 as y, where x = ~s0 & ~s1 and y = (~s0 & s1) | (~s0 & ~s2) over the qualified bits s. When no source qualifies, the code is 3.
- R7: While `int_ack_i` is 1, `vec_oe_o` is 1 and `vec_o` equals `VEC_BASE` with its two low bits replaced by the code. While `int_ack_i` is 0, `vec_oe_o` is 0 and `vec_o` is 0.
- R8: A clock edge with `int_ack_i` at 1 clears the global enable. This wins over a command 4 in the same cycle. Acknowledge leaves the pending and allow bits unchanged.
- R9: Command codes 0, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request pulses, one per source |
| cmd_i | input | 3 | Software command code |
| cmd_bits_i | input | 4 | Source bitmap the command acts on |
| int_ack_i | input | 1 | Interrupt acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector address, zero when not driven |
| vec_oe_o | output | 1 | Output enable for the vector bus buffer |

## Verification
The bench builds the block with four sources, an 8-bit vector and a `VEC_BASE` of 8'hB7. That base has both low bits set, so any failure to overwrite them with the code shows up at once. With four sources, every pairing of a pending pattern and an allow pattern (256 combinations) can be driven. For each one the bench checks the interrupt line, the acknowledged vector, the enable drop on acknowledge and the survival of the pending bits. Directed runs cover the set-over-clear collision, acknowledge racing enable, and the unused command codes.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ALLOW_SET = 3'd1,
    CMD_ALLOW_CLR = 3'd2,
    CMD_PEND_CLR  = 3'd3,
    CMD_GLOBAL_ON = 3'd4,
    CMD_GLOBAL_OFF= 3'd5
  } pic_cmd_e;

  // Index of the lowest set bit among the first n bits; n-1 when none is set.
  function automatic int first_set(input logic [31:0] v, input int n);
    int r;
    r = n - 1;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [2:0]   cmd,
  input  logic [N-1:0] bits,
  output logic [N-1:0] pend,
  output logic [N-1:0] allow
);
  import pic_pkg::*;

  logic clr_pend, set_allow, clr_allow;
  assign clr_pend  = (cmd == CMD_PEND_CLR);
  assign set_allow = (cmd == CMD_ALLOW_SET);
  assign clr_allow = (cmd == CMD_ALLOW_CLR);

  for (genvar k = 0; k < N; k++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[k]  <= 1'b0;
        allow[k] <= 1'b0;
      end else begin
        if (req[k])                    pend[k] <= 1'b1;
        else if (clr_pend && bits[k])  pend[k] <= 1'b0;
        if (set_allow && bits[k])      allow[k] <= 1'b1;
        else if (clr_allow && bits[k]) allow[k] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N  = 4,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  live,
  output logic          ist,
  output logic [CW-1:0] code
);
  import pic_pkg::*;

  assign ist  = |live;
  assign code = CW'(first_set(32'(live), N));

endmodule

// File: rtl/pic_gate.sv
module pic_gate #(
  parameter int             CW       = 2,
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic             ack,
  input  logic             ist,
  input  logic [CW-1:0]    code,
  output logic             gen,
  output logic             irq,
  output logic [VEC_W-1:0] vec,
  output logic             vec_oe
);
  import pic_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gen <= 1'b0;
    else if (ack)                   gen <= 1'b0;
    else if (cmd == CMD_GLOBAL_ON)  gen <= 1'b1;
    else if (cmd == CMD_GLOBAL_OFF) gen <= 1'b0;
  end

  assign irq    = gen & ist;
  assign vec_oe = ack;
  assign vec    = ack ? {VEC_BASE[VEC_W-1:CW], code} : '0;

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int               N        = 4,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic [2:0]       cmd_i,
  input  logic [N-1:0]     cmd_bits_i,
  input  logic             int_ack_i,
  output logic             int_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);
  localparam int CW = $clog2(N);

  logic [N-1:0]  pend, allow, live;
  logic          ist, gen;
  logic [CW-1:0] code;

  pic_src_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .req(req_i), .cmd(cmd_i), .bits(cmd_bits_i),
    .pend(pend), .allow(allow)
  );

  assign live = pend & allow;

  pic_prio_enc #(.N(N), .CW(CW)) u_enc (
    .live(live), .ist(ist), .code(code)
  );

  pic_gate #(.CW(CW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_i), .ack(int_ack_i), .ist(ist),
    .code(code), .gen(gen), .irq(int_o), .vec(vec_o), .vec_oe(vec_oe_o)
  );

endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int               N        = 4,
  parameter int               CW       = 2,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req_i,
  input logic [2:0]       cmd_i,
  input logic [N-1:0]     cmd_bits_i,
  input logic             int_ack_i,
  input logic             int_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_oe_o,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     live,
  input logic             ist,
  input logic [CW-1:0]    code
);
  import pic_pkg::*;

  assert_req_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |req_i |=> ((pend & $past(req_i)) == $past(req_i)));

  assert_pend_falls_by_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |pend |=> ((($past(pend) & ~pend) &
               ~(($past(cmd_i) == CMD_PEND_CLR) ? $past(cmd_bits_i) : '0)) == '0));

  assert_ack_drops_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_i |=> !int_o);

  assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> (vec_o[VEC_W-1:CW] == VEC_BASE[VEC_W-1:CW]));

  assert_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe_o && ist) |-> (live[code] && ((live & ((N'(1) << code) - N'(1))) == '0)));

  assert_int_needs_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (live != '0));

endmodule

bind pic_ctrl pic_ctrl_chk #(.N(N), .CW(CW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .cmd_i(cmd_i), .cmd_bits_i(cmd_bits_i),
  .int_ack_i(int_ack_i), .int_o(int_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o),
  .pend(pend), .live(live), .ist(ist), .code(code)
);

// File: tb/pic_ctrl_bench.sv
module pic_ctrl_bench;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] BASE       = 8'hB7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [2:0] cmd = '0;
  logic [3:0] bits = '0;
  logic       ack = 1'b0;
  logic       int_o;
  logic [7:0] vec;
  logic       vec_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_ctrl #(.N(4), .VEC_W(8), .VEC_BASE(BASE)) u_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd), .cmd_bits_i(bits),
    .int_ack_i(ack), .int_o(int_o), .vec_o(vec), .vec_oe_o(vec_oe)
  );

  function automatic logic [1:0] exp_code(input logic [3:0] s);
    logic x, y;
    x = ~s[0] & ~s[1];
    y = (~s[0] & s[1]) | (~s[0] & ~s[2]);
    return {x, y};
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [3:0] b, input logic [3:0] r, input logic a);
    cmd = c; bits = b; req = r; ack = a;
    @(negedge clk);
    cmd = '0; bits = '0; req = '0; ack = 1'b0;
  endtask

  // Hold ack for one cycle, checking the driven vector before the edge.
  task automatic ack_check(input logic [1:0] c, input string tag);
    ack = 1'b1;
    #1;
    check(vec_oe, 1, {tag, " oe"});
    check(vec, {BASE[7:2], c}, {tag, " vec"});
    @(negedge clk);
    ack = 1'b0;
    #1;
    check(int_o, 0, "R8 int after ack");
    check(vec_oe, 0, "R7 oe idle");
    check(vec, 0, "R7 vec idle");
  endtask

  task automatic wipe();
    drive(3'd3, 4'hF, 4'h0, 1'b0);
    drive(3'd2, 4'hF, 4'h0, 1'b0);
    drive(3'd5, 4'h0, 4'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check(int_o, 0, "R1 int");
    check(vec_oe, 0, "R1 oe");
    check(vec, 0, "R1 vec");
    rst_n = 1'b1;
    @(negedge clk);
    drive(3'd4, 4'h0, 4'h0, 1'b0);
    drive(3'd1, 4'hF, 4'h0, 1'b0);
    check(int_o, 0, "R1 nothing pending after reset");

    // Exhaustive pending x allow sweep: R4, R5, R6, R7, R8
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 16; a++) begin
        wipe();
        drive(3'd1, 4'(a), 4'h0, 1'b0);
        drive(3'd0, 4'h0, 4'(p), 1'b0);
        check(int_o, 0, "R5 gen off");
        drive(3'd4, 4'h0, 4'h0, 1'b0);
        check(int_o, ((p & a) != 0) ? 1 : 0, "R5 int");
        ack_check(exp_code(4'(p & a)), "R6 R7");
        drive(3'd4, 4'h0, 4'h0, 1'b0);
        check(int_o, ((p & a) != 0) ? 1 : 0, "R8 pend kept after ack");
      end
    end

    // R2: sticky, masked request kept pending (R4)
    wipe();
    drive(3'd4, 4'h0, 4'h0, 1'b0);
    drive(3'd0, 4'h0, 4'b0100, 1'b0);
    drive(3'd0, 4'h0, 4'h0, 1'b0);
    check(int_o, 0, "R4 masked");
    drive(3'd1, 4'b0100, 4'h0, 1'b0);
    check(int_o, 1, "R2 sticky");
    ack_check(2'd2, "R2 code");

    // R3: set wins over clear, then plain clear
    wipe();
    drive(3'd1, 4'hF, 4'h0, 1'b0);
    drive(3'd4, 4'h0, 4'h0, 1'b0);
    drive(3'd0, 4'h0, 4'b0010, 1'b0);
    drive(3'd3, 4'b0010, 4'b0010, 1'b0);
    check(int_o, 1, "R3 set wins");
    drive(3'd3, 4'b0010, 4'h0, 1'b0);
    check(int_o, 0, "R3 clear");

    // R9: unused codes change nothing
    drive(3'd0, 4'h0, 4'b1000, 1'b0);
    drive(3'd6, 4'hF, 4'h0, 1'b0);
    drive(3'd7, 4'hF, 4'h0, 1'b0);
    drive(3'd0, 4'hF, 4'h0, 1'b0);
    check(int_o, 1, "R9 unused codes");
    ack_check(2'd3, "R9 code");

    // R5: global off
    drive(3'd4, 4'h0, 4'h0, 1'b0);
    check(int_o, 1, "R5 on");
    drive(3'd5, 4'h0, 4'h0, 1'b0);
    check(int_o, 0, "R5 off");

    // R8: ack wins over enable in the same cycle
    drive(3'd4, 4'h0, 4'h0, 1'b1);
    check(int_o, 0, "R8 ack beats enable");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule